// File: doc/BRIEF.md
# Bipolar Line Encoder with Zero Substitution

This block turns a unipolar transmit bit stream into a pair of return-to-zero rail signals, one for positive pulses and one for negative pulses, ready for a line interface. Each bit is taken on a bit strobe (`bit_ce`). Marks are sent with alternating polarity and zeros send nothing. When substitution is enabled, long runs of zeros are replaced by patterns that contain deliberate bipolar violations. The run length is eight in the 1.544 Mb/s rate family and four in the 2.048 Mb/s family, so that the far end keeps its clock recovery.

Each bit passes through an eight-stage delay line before it is encoded. This gives the substitution logic a full run of lookahead, and the latency is the same in every mode. Two maintenance functions are also built in. The first injects a single test violation on each rising edge of a control input. The second replaces the transmit data with all ones when the receive side reports loss of signal and automatic alarm insertion is enabled.

Top module: `bipolar_line_encoder`

## Requirements
- R1: After synchronous reset both rails are low, the stored polarity is negative so the first pulse sent is positive, and the HDB3 mark count starts even.
- R2: The two rails are never high together.
- R3: With `subst_en` = 0 the code is plain AMI in both rate families. Each mark (data 1) drives the rail opposite to the previous pulse, and each zero drives neither rail.
- R4: With `e1_sel` = 0 and `subst_en` = 1 (B8ZS), every run of eight zeros is sent as 0,0,0,V,B,0,V,B. V has the same polarity as the pulse before it, B has the opposite polarity, and the sequence ends after its eighth bit.
- R5: With `e1_sel` = 1 and `subst_en` = 1 (HDB3), every run of four zeros is sent as 0,0,0,V if an odd number of pulses has been sent since the last V, and as B,0,0,V if the count is even. B alternates polarity and V repeats the polarity of the pulse before it.
- R6: The rails for a bit appear after the eighth `bit_ce` strobe that follows the strobe that took the bit, in every mode. On clock cycles without a strobe the rails hold their value.
- R7: While `rx_los` = 1 and `auto_ais_en` = 1, the incoming data is replaced by ones before encoding. `rx_los` alone has no effect.
- R8: A 0-to-1 transition of `bpv_force` makes the next data mark go out with the same polarity as the previous pulse, and the stored polarity is not flipped. Holding `bpv_force` high adds no further violations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_ce | input | 1 | Bit strobe; one data bit per strobe |
| tx_bit | input | 1 | Unipolar transmit data |
| e1_sel | input | 1 | 1 selects the 2.048 Mb/s family (HDB3), 0 the 1.544 Mb/s family (B8ZS) |
| subst_en | input | 1 | 1 enables zero substitution, 0 selects AMI |
| bpv_force | input | 1 | Test violation request, acting on its rising edge |
| rx_los | input | 1 | Loss of signal reported by the receive side |
| auto_ais_en | input | 1 | Enables all-ones forcing while `rx_los` is high |
| line_pos | output | 1 | Positive pulse rail |
| line_neg | output | 1 | Negative pulse rail |

## Verification
A wrong polarity register shows up at the rails on the next pulse, as a repeated polarity outside any substitution pattern. A wrong HDB3 parity bit or a wrong sequencer phase shows up within one run of four or eight zeros, as a missing B, a misplaced V, or a run that is cut short. Because every bit leaves exactly eight strobes after it enters, each error can be traced to one input bit. A stuck pending-violation flag shows as extra same-polarity pairs on the next marks, and a lost flag shows as no violation at all.

// File: rtl/ble_pkg.sv
package ble_pkg;

    localparam int B8_RUN = 8;
    localparam int HD_RUN = 4;
    localparam int PH_W   = $clog2(B8_RUN);

    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_MARK = 2'd1,
        SYM_BIP  = 2'd2,
        SYM_VIOL = 2'd3
    } sym_e;

    typedef struct packed {
        logic p;
        logic n;
    } rail_t;

    // 8-zero replacement: positions 3 and 6 violate, 4 and 7 balance
    function automatic sym_e b8zs_sym(input logic [PH_W-1:0] ph);
        case (ph)
            PH_W'(3), PH_W'(6): return SYM_VIOL;
            PH_W'(4), PH_W'(7): return SYM_BIP;
            default:            return SYM_ZERO;
        endcase
    endfunction

    // 4-zero replacement: optional leading balance pulse, violation last
    function automatic sym_e hdb3_sym(input logic [PH_W-1:0] ph, input logic lead_b);
        if (ph == PH_W'(0) && lead_b) return SYM_BIP;
        if (ph == PH_W'(HD_RUN-1))    return SYM_VIOL;
        return SYM_ZERO;
    endfunction

endpackage

// File: rtl/ble_delay_line.sv
module ble_delay_line #(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             din,
    input  logic             los,
    input  logic             ais_en,
    output logic [DEPTH-1:0] data_o,
    output logic [DEPTH-1:0] valid_o
);
    logic in_bit;

    always_comb in_bit = (los && ais_en) ? 1'b1 : din;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            valid_o <= '0;
        end else if (ce) begin
            data_o  <= {data_o[DEPTH-2:0], in_bit};
            valid_o <= {valid_o[DEPTH-2:0], 1'b1};
        end
    end

    // R7: forced ones enter the line while alarm insertion is active
    p_ais_forces_one_r7: assert property (@(posedge clk) disable iff (rst)
        (ce && los && ais_en) |=> data_o[0]);

endmodule

// File: rtl/ble_sub_seq.sv
module ble_sub_seq
    import ble_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             e1_mode,
    input  logic             sub_en,
    input  logic [DEPTH-1:0] data_i,
    input  logic [DEPTH-1:0] valid_i,
    input  logic             odd_marks,
    output sym_e             sym_o
);
    localparam int TOP = DEPTH - 1;

    logic            active, run_e1, use_b;
    logic [PH_W-1:0] phase;
    logic            b8_zero, hd_zero, start;
    logic            cur_e1, cur_b;
    logic [PH_W-1:0] cur_phase, last_ph;

    always_comb begin
        b8_zero   = ~|data_i[TOP -: B8_RUN] && &valid_i[TOP -: B8_RUN];
        hd_zero   = ~|data_i[TOP -: HD_RUN] && &valid_i[TOP -: HD_RUN];
        start     = sub_en && !active && (e1_mode ? hd_zero : b8_zero);
        cur_phase = active ? phase  : '0;
        cur_e1    = active ? run_e1 : e1_mode;
        cur_b     = active ? use_b  : !odd_marks;
        last_ph   = cur_e1 ? PH_W'(HD_RUN-1) : PH_W'(B8_RUN-1);
        if (active || start)
            sym_o = cur_e1 ? hdb3_sym(cur_phase, cur_b) : b8zs_sym(cur_phase);
        else if (data_i[TOP] && valid_i[TOP])
            sym_o = SYM_MARK;
        else
            sym_o = SYM_ZERO;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            phase  <= '0;
            run_e1 <= 1'b0;
            use_b  <= 1'b0;
        end else if (ce && (active || start)) begin
            if (start) begin
                run_e1 <= e1_mode;
                use_b  <= !odd_marks;
            end
            if (cur_phase == last_ph) begin
                active <= 1'b0;
                phase  <= '0;
            end else begin
                active <= 1'b1;
                phase  <= PH_W'(cur_phase + 1'b1);
            end
        end
    end

    // R4: an eight-bit replacement ends after its last position
    p_run_closes_r4: assert property (@(posedge clk) disable iff (rst)
        (ce && active && !run_e1 && phase == PH_W'(B8_RUN-1)) |=> !active);

    // R5: a four-bit replacement never reaches past position three
    p_short_run_r5: assert property (@(posedge clk) disable iff (rst)
        (active && run_e1) |-> (phase < PH_W'(HD_RUN)));

endmodule

// File: rtl/ble_rail_drv.sv
module ble_rail_drv
    import ble_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic bpv_req,
    input  sym_e sym_i,
    output logic pos_o,
    output logic neg_o,
    output logic odd_marks_o
);
    rail_t rails;
    logic  last_pos, bpv_q, pend;
    logic  rise, pulse, pol, flip;

    always_comb begin
        rise  = bpv_req && !bpv_q;
        pulse = 1'b0;
        pol   = 1'b0;
        flip  = 1'b0;
        unique case (sym_i)
            SYM_MARK: begin
                pulse = 1'b1;
                pol   = pend ? last_pos : !last_pos;
                flip  = !pend;
            end
            SYM_BIP: begin
                pulse = 1'b1;
                pol   = !last_pos;
                flip  = 1'b1;
            end
            SYM_VIOL: begin
                pulse = 1'b1;
                pol   = last_pos;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rails       <= '0;
            last_pos    <= 1'b0;
            odd_marks_o <= 1'b0;
            bpv_q       <= 1'b0;
            pend        <= 1'b0;
        end else begin
            bpv_q <= bpv_req;
            pend  <= (pend && !(ce && sym_i == SYM_MARK)) || rise;
            if (ce) begin
                rails <= pulse ? rail_t'{p: pol, n: !pol} : rail_t'('0);
                if (flip) last_pos <= !last_pos;
                if (sym_i == SYM_VIOL)
                    odd_marks_o <= 1'b0;
                else if (sym_i == SYM_MARK || sym_i == SYM_BIP)
                    odd_marks_o <= !odd_marks_o;
            end
        end
    end

    assign pos_o = rails.p;
    assign neg_o = rails.n;

    // R2: one rail at a time
    p_rails_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        !(pos_o && neg_o));

    // R6: rails move only on a bit strobe
    p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(pos_o) && $stable(neg_o)));

    // R3: an ordinary mark takes the opposite polarity
    p_mark_alternates_r3: assert property (@(posedge clk) disable iff (rst)
        (ce && sym_i == SYM_MARK && !pend) |=> (pos_o == !$past(last_pos)) && (pos_o || neg_o));

    // R8: a pending violation is consumed by the next mark
    p_inject_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (ce && sym_i == SYM_MARK && pend && !rise) |=> !pend);

endmodule

// File: rtl/bipolar_line_encoder.sv
module bipolar_line_encoder
    import ble_pkg::*;
#(
    parameter int PIPE_DEPTH = B8_RUN   // must be at least B8_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_ce,
    input  logic tx_bit,
    input  logic e1_sel,
    input  logic subst_en,
    input  logic bpv_force,
    input  logic rx_los,
    input  logic auto_ais_en,
    output logic line_pos,
    output logic line_neg
);
    logic [PIPE_DEPTH-1:0] pipe_data, pipe_valid;
    logic                  odd_marks;
    sym_e                  sym;

    ble_delay_line #(.DEPTH(PIPE_DEPTH)) u_line (
        .clk     (clk),
        .rst     (rst),
        .ce      (bit_ce),
        .din     (tx_bit),
        .los     (rx_los),
        .ais_en  (auto_ais_en),
        .data_o  (pipe_data),
        .valid_o (pipe_valid)
    );

    ble_sub_seq #(.DEPTH(PIPE_DEPTH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ce        (bit_ce),
        .e1_mode   (e1_sel),
        .sub_en    (subst_en),
        .data_i    (pipe_data),
        .valid_i   (pipe_valid),
        .odd_marks (odd_marks),
        .sym_o     (sym)
    );

    ble_rail_drv u_drv (
        .clk         (clk),
        .rst         (rst),
        .ce          (bit_ce),
        .bpv_req     (bpv_force),
        .sym_i       (sym),
        .pos_o       (line_pos),
        .neg_o       (line_neg),
        .odd_marks_o (odd_marks)
    );

endmodule

// File: tb/bipolar_line_encoder_bench.sv
module bipolar_line_encoder_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_ce = 1'b0, tx_bit = 1'b0, e1_sel = 1'b0, subst_en = 1'b0;
    logic bpv_force = 1'b0, rx_los = 1'b0, auto_ais_en = 1'b0;
    logic line_pos, line_neg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bipolar_line_encoder u_bipolar_line_encoder (
        .clk(clk), .rst(rst), .bit_ce(bit_ce), .tx_bit(tx_bit),
        .e1_sel(e1_sel), .subst_en(subst_en), .bpv_force(bpv_force),
        .rx_los(rx_los), .auto_ais_en(auto_ais_en),
        .line_pos(line_pos), .line_neg(line_neg)
    );

    typedef struct packed {
        logic        e1;
        logic        sub;
        logic        los;
        logic        ais;
        logic [15:0] d;
        logic [15:0] p;
        logic [15:0] n;
    } vec_t;

    // bit strings read left to right in time order
    localparam vec_t VEC [7] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'b1101_0000_0000_1001, 16'b1001_0000_0000_0001, 16'b0100_0000_0000_1000}, // R3 AMI slow family
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'b1000_0000_0100_0000, 16'b1000_1000_1000_0000, 16'b0000_0101_0100_0000}, // R4 B8ZS
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'b1000_0100_0010_0001, 16'b1000_1000_0010_0010, 16'b0000_0100_0100_0001}, // R5 odd count
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'b0000_0000_1100_0000, 16'b1001_0000_1010_0100, 16'b0000_1001_0100_0000}, // R5 even count
        '{1'b0, 1'b1, 1'b1, 1'b0, 16'b0000_0000_0000_0000, 16'b0000_1010_0000_1010, 16'b0001_0001_0001_0001}, // R7 LOS alone
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'b0000_0000_0000_0000, 16'b1010_1010_1010_1010, 16'b0101_0101_0101_0101}, // R7 forced ones
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'b1000_0000_0000_0001, 16'b1000_0000_0000_0000, 16'b0000_0000_0000_0001}  // R3 AMI fast family
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 6:    return "R3";
            1:       return "R4";
            2, 3:    return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: rails actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bit_ce = 1'b0;
        bpv_force = 1'b0;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state of the rails
        chk(!line_pos && !line_neg, "R1", {line_pos, line_neg}, 2'b00);

        // vector table
        for (int v = 0; v < 7; v++) begin
            do_reset();
            e1_sel = VEC[v].e1;
            subst_en = VEC[v].sub;
            rx_los = VEC[v].los;
            auto_ais_en = VEC[v].ais;
            for (int t = 0; t < 24; t++) begin
                tx_bit = (t < 16) ? VEC[v].d[15-t] : 1'b1;
                bit_ce = 1'b1;
                step();
                if (v == 0 && t == 7)   // R6: nothing yet before the eighth strobe
                    chk(!line_pos && !line_neg, "R6", {line_pos, line_neg}, 2'b00);
                if (t >= 8)
                    chk({line_pos, line_neg} == {VEC[v].p[15-(t-8)], VEC[v].n[15-(t-8)]},
                        vec_tag(v), {line_pos, line_neg},
                        {VEC[v].p[15-(t-8)], VEC[v].n[15-(t-8)]});
            end
            // R6: rails hold while no strobe arrives
            if (v == 0) begin
                logic [1:0] held;
                held = {line_pos, line_neg};
                bit_ce = 1'b0;
                for (int h = 0; h < 6; h++) begin
                    tx_bit = h[0];
                    step();
                    chk({line_pos, line_neg} == held, "R6", {line_pos, line_neg}, held);
                end
            end
        end
        rx_los = 1'b0;
        auto_ais_en = 1'b0;

        // R8: test violation on rising edges only, AMI with all ones
        begin
            int viol = 0;
            int pulses = 0;
            logic prev_p = 1'b0;
            bit have_prev = 1'b0;
            do_reset();
            e1_sel = 1'b0;
            subst_en = 1'b0;
            tx_bit = 1'b1;
            bit_ce = 1'b1;
            for (int t = 0; t < 72; t++) begin
                bpv_force = (t >= 12 && t < 40) || (t >= 46 && t < 60);
                step();
                if (t >= 8) begin
                    if (line_pos || line_neg) begin
                        pulses++;
                        if (have_prev && prev_p == line_pos) viol++;
                        prev_p = line_pos;
                        have_prev = 1'b1;
                    end
                end
                if (t == 8)   // R1: first pulse after reset is positive
                    chk(line_pos && !line_neg, "R1", {line_pos, line_neg}, 2'b10);
                if (t == 44)  // R8: one violation despite the long hold
                    chk(viol == 1, "R8", 2'(viol), 2'd1);
            end
            chk(viol == 2, "R8", 2'(viol), 2'd2);
            chk(pulses == 64, "R3", 2'(pulses == 64), 2'b01);
        end

        // R1: reset mid-stream clears the rails
        rst = 1'b1;
        step();
        rst = 1'b0;
        bit_ce = 1'b0;
        chk(!line_pos && !line_neg, "R1", {line_pos, line_neg}, 2'b00);

        finish_run();
    end

endmodule